// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a pipelined arithmetic slice for filters and dot products. Two 25-bit operands, D and A, first meet in a pre-adder. The pre-adder forms their sum or their difference, or it passes A through unchanged. Its 25-bit result is multiplied by an 18-bit signed operand B. The signed product is sign-extended to 48 bits and goes to a 48-bit adder. That adder adds the product to, or subtracts it from, a second operand Z. Z is zero, the 48-bit C input, or the slice's own result register. Choosing the result register turns the slice into an accumulator. When the pre-adder adds two taps that share a coefficient, a symmetric filter needs only half as many multiplies.

Every cycle carries its own 5-bit opcode, so a stream can mix plain products, products with an offset, and running sums. The data flow is a valid-qualified stream with no back-pressure. The slice has no ready output and never stalls. It takes a new operation on every cycle in which `in_valid` is high. The consumer must accept every result in the cycle where `out_valid` is high. An upstream stage that cannot keep data coming holds `in_valid` low. A downstream stage that needs flow control must add its own buffering.

Top module: `mac_slice`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every pipeline register. Afterwards `p_out` reads 0 and `out_valid` reads 0, and the first feedback operation after reset accumulates onto zero.
- R2: An operation presented with `in_valid` high before rising edge k appears on `p_out` with `out_valid` high after rising edge k+2, which is three register stages later. `out_valid` follows `in_valid` with exactly this delay, and results come out in the order the operations went in.
- R3: With opcode bit 4 = 0 and bit 3 = 0, the multiplier's 25-bit operand is D + A, truncated to 25 bits and taken as signed.
- R4: With opcode bit 4 = 0 and bit 3 = 1, the multiplier's 25-bit operand is D − A, truncated to 25 bits.
- R5: With opcode bit 4 = 1, the multiplier's 25-bit operand is A alone, whatever bit 3 holds.
- R6: The product is the full signed product of the 25-bit pre-adder result and the 18-bit B, sign-extended to 48 bits as M.
- R7: Opcode bits [1:0] select Z: 00 gives zero, 01 gives C, 10 gives the current result register (feedback), and 11 also gives zero.
- R8: Opcode bit 2 = 0 gives P = Z + M, and bit 2 = 1 gives P = Z − M.
- R9: The adder wraps modulo 2^48 and does not saturate.
- R10: The result register changes only when an operation reaches the last stage. Cycles with `in_valid` low leave `p_out` unchanged whatever the other inputs hold, and the next feedback operation builds on the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| a_in | input | 25 | Signed operand A (pre-adder and bypass input) |
| d_in | input | 25 | Signed operand D (pre-adder input) |
| b_in | input | 18 | Signed multiplier operand B |
| c_in | input | 48 | Addend C for Z select 01 |
| op_in | input | 5 | Opcode: [4] pre-adder bypass, [3] pre-subtract, [2] post-subtract, [1:0] Z select |
| out_valid | output | 1 | `p_out` carries a new result this cycle |
| p_out | output | 48 | Result register P |

## Verification
Every result is due on the third rising edge after its operands are presented. The bench drives inputs on the falling edge. With each operation it queues the expected value and the cycle count at which that value must appear. The monitor samples on falling edges and requires `out_valid` exactly in the queued cycle with the queued value. In every cycle without a result, it requires that `p_out` still holds the last expected result.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // Z operand select, opcode bits [1:0]
  typedef enum logic [1:0] {
    Z_ZERO = 2'b00,
    Z_CIN  = 2'b01,
    Z_FEED = 2'b10,
    Z_RSVD = 2'b11
  } zsel_e;

  // opcode layout: [4] bypass, [3] pre-subtract, [2] post-subtract, [1:0] Z select
  typedef struct packed {
    logic  pre_byp;
    logic  pre_sub;
    logic  post_sub;
    zsel_e zsel;
  } op_t;

  localparam int OP_W = $bits(op_t);
endpackage

// File: rtl/mac_in_reg.sv
module mac_in_reg
  import mac_pkg::*;
#(
  parameter int AW = 25,
  parameter int BW = 18,
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] d_i,
  input  logic [BW-1:0] b_i,
  input  logic [PW-1:0] c_i,
  input  op_t           op_i,
  output logic          v_o,
  output logic [AW-1:0] a_o,
  output logic [AW-1:0] d_o,
  output logic [BW-1:0] b_o,
  output logic [PW-1:0] c_o,
  output op_t           op_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_o  <= 1'b0;
      a_o  <= '0;
      d_o  <= '0;
      b_o  <= '0;
      c_o  <= '0;
      op_o <= '0;
    end else begin
      v_o  <= v_i;
      a_o  <= a_i;
      d_o  <= d_i;
      b_o  <= b_i;
      c_o  <= c_i;
      op_o <= op_i;
    end
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int AW = 25,
  parameter int BW = 18,
  parameter int PW = 48,
  localparam int MW = AW + BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] d_i,
  input  logic [BW-1:0] b_i,
  input  logic [PW-1:0] c_i,
  input  op_t           op_i,
  output logic          v_o,
  output logic [MW-1:0] prod_o,
  output logic [PW-1:0] c_o,
  output op_t           op_o
);
  logic signed [AW-1:0] pre_s;
  logic signed [BW-1:0] b_s;
  logic signed [MW-1:0] prod_d;

  // pre-adder, result kept to AW bits
  always_comb begin
    if (op_i.pre_byp)
      pre_s = a_i;
    else if (op_i.pre_sub)
      pre_s = d_i - a_i;
    else
      pre_s = d_i + a_i;
  end

  assign b_s    = b_i;
  assign prod_d = MW'(pre_s) * MW'(b_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o    <= 1'b0;
      prod_o <= '0;
      c_o    <= '0;
      op_o   <= '0;
    end else begin
      v_o    <= v_i;
      prod_o <= prod_d;
      c_o    <= c_i;
      op_o   <= op_i;
    end
  end

  // R2
  vld_fwd_chk: assert property (@(posedge clk) disable iff (rst) v_i |=> v_o);
  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst) !v_i |=> !v_o);
endmodule

// File: rtl/mac_post.sv
module mac_post
  import mac_pkg::*;
#(
  parameter int MW = 43,
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [MW-1:0] prod_i,
  input  logic [PW-1:0] c_i,
  input  op_t           op_i,
  output logic          v_o,
  output logic [PW-1:0] p_o
);
  logic [PW-1:0] m_ext;
  logic [PW-1:0] z_op;
  logic [PW-1:0] sum_d;

  generate
    if (PW > MW) begin : g_sext
      assign m_ext = {{(PW-MW){prod_i[MW-1]}}, prod_i};
    end else begin : g_trunc
      assign m_ext = prod_i[PW-1:0];
    end
  endgenerate

  always_comb begin
    unique case (op_i.zsel)
      Z_CIN:   z_op = c_i;
      Z_FEED:  z_op = p_o;
      default: z_op = '0;
    endcase
  end

  assign sum_d = op_i.post_sub ? (z_op - m_ext) : (z_op + m_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      p_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) p_o <= sum_d;
    end
  end

  // R10
  p_hold_chk: assert property (@(posedge clk) disable iff (rst) !v_i |=> $stable(p_o));
  // R7
  z_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (v_i && op_i.zsel == Z_ZERO && !op_i.post_sub) |=> p_o == $past(m_ext));
  // R9
  z_feed_chk: assert property (@(posedge clk) disable iff (rst)
    (v_i && op_i.zsel == Z_FEED && !op_i.post_sub) |=> p_o == $past(p_o) + $past(m_ext));
  // R8
  c_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (v_i && op_i.zsel == Z_CIN && op_i.post_sub) |=> p_o == $past(c_i) - $past(m_ext));
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_pkg::*;
#(
  parameter int AW = 25,
  parameter int BW = 18,
  parameter int PW = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [AW-1:0]   a_in,
  input  logic [AW-1:0]   d_in,
  input  logic [BW-1:0]   b_in,
  input  logic [PW-1:0]   c_in,
  input  logic [OP_W-1:0] op_in,
  output logic            out_valid,
  output logic [PW-1:0]   p_out
);
  localparam int MW = AW + BW;

  logic          s1_v;
  logic [AW-1:0] s1_a;
  logic [AW-1:0] s1_d;
  logic [BW-1:0] s1_b;
  logic [PW-1:0] s1_c;
  op_t           s1_op;

  logic          s2_v;
  logic [MW-1:0] s2_prod;
  logic [PW-1:0] s2_c;
  op_t           s2_op;

  mac_in_reg #(.AW(AW), .BW(BW), .PW(PW)) u_in (
    .clk(clk), .rst(rst),
    .v_i(in_valid), .a_i(a_in), .d_i(d_in), .b_i(b_in), .c_i(c_in), .op_i(op_t'(op_in)),
    .v_o(s1_v), .a_o(s1_a), .d_o(s1_d), .b_o(s1_b), .c_o(s1_c), .op_o(s1_op)
  );

  mac_mult #(.AW(AW), .BW(BW), .PW(PW)) u_mult (
    .clk(clk), .rst(rst),
    .v_i(s1_v), .a_i(s1_a), .d_i(s1_d), .b_i(s1_b), .c_i(s1_c), .op_i(s1_op),
    .v_o(s2_v), .prod_o(s2_prod), .c_o(s2_c), .op_o(s2_op)
  );

  mac_post #(.MW(MW), .PW(PW)) u_post (
    .clk(clk), .rst(rst),
    .v_i(s2_v), .prod_i(s2_prod), .c_i(s2_c), .op_i(s2_op),
    .v_o(out_valid), .p_o(p_out)
  );
endmodule

// File: tb/mac_slice_bench.sv
`timescale 1ns/1ps
module mac_slice_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [24:0] a_in = '0, d_in = '0;
  logic [17:0] b_in = '0;
  logic [47:0] c_in = '0;
  logic [4:0]  op_in = '0;
  logic        out_valid;
  logic [47:0] p_out;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  logic [47:0] acc = '0, last_p = '0;
  logic [47:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mac_slice u_mac_slice (.*);

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] model(logic [24:0] a, logic [24:0] d, logic [17:0] b,
                                        logic [47:0] c, logic [4:0] op, logic [47:0] fb);
    logic signed [24:0] pre;
    logic signed [17:0] bs;
    longint m;
    logic [47:0] z;
    if (op[4]) pre = a;
    else if (op[3]) pre = d - a;
    else pre = d + a;
    bs = b;
    m = longint'(pre) * longint'(bs);
    case (op[1:0])
      2'b01: z = c;
      2'b10: z = fb;
      default: z = '0;
    endcase
    return op[2] ? z - m[47:0] : z + m[47:0];
  endfunction

  task automatic send(input logic [24:0] a, input logic [24:0] d, input logic [17:0] b,
                      input logic [47:0] c, input logic [4:0] op, input string tag);
    @(negedge clk);
    a_in = a; d_in = d; b_in = b; c_in = c; op_in = op; in_valid = 1'b1;
    acc = model(a, d, b, c, op, acc);
    exp_q.push_back(acc); due_q.push_back(cyc + 3); tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      a_in = 25'($urandom); d_in = 25'($urandom); b_in = 18'($urandom);
      c_in = {16'($urandom), 32'($urandom)}; op_in = 5'b00001;
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected out_valid", p_out, last_p);
        else begin
          logic [47:0] e; int du; string t;
          e = exp_q.pop_front(); du = due_q.pop_front(); t = tag_q.pop_front();
          chk(p_out == e, t, p_out, e);
          chk(cyc == du, "R2 latency", 48'(cyc), 48'(du));
          last_p = e;
        end
      end else begin
        chk(p_out == last_p, "R10 hold", p_out, last_p);
        if (due_q.size() > 0 && due_q[0] <= cyc)
          chk(0, "R2 missing out_valid", 48'(cyc), 48'(due_q[0]));
      end
    end
  end

  task automatic do_reset();
    idle(5);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    acc = '0; last_p = '0;
    chk(p_out == 48'd0, "R1 reset p_out", p_out, 48'd0);
    chk(out_valid == 1'b0, "R1 reset out_valid", 48'(out_valid), 48'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    chk(0, "watchdog expired", 48'(cyc), 48'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(p_out == 48'd0, "R1 initial p_out", p_out, 48'd0);
    chk(out_valid == 1'b0, "R1 initial out_valid", 48'(out_valid), 48'd0);
    // R1: feedback starts from zero
    send(25'd2, 25'd1, 18'd4, 48'd0, 5'b00010, "R1 feedback from zero");
    // R3 R6
    send(25'd3, 25'd4, 18'd5, 48'd0, 5'b00000, "R3 pre-add");
    // R4
    send(25'd10, 25'd4, 18'd7, 48'd0, 5'b01000, "R4 pre-subtract");
    // R5 bypass overrides pre-subtract
    send(-25'sd3, 25'd100, -18'sd9, 48'd0, 5'b11000, "R5 bypass");
    // R7 C add, R8 C subtract
    send(25'd6, 25'd1, 18'd3, 48'd1000, 5'b00001, "R7 z=C add");
    send(25'd6, 25'd1, 18'd3, 48'd1000, 5'b00101, "R8 z=C subtract");
    // R7 reserved select gives zero
    send(25'd1, 25'd1, 18'd11, 48'hABCDEF, 5'b00011, "R7 z=11 zero");
    // R7 feedback chain back to back
    for (int i = 0; i < 5; i++)
      send(25'(i), 25'd3, 18'(i + 2), 48'd0, 5'b00010, "R7 feedback chain");
    // R10: junk while idle, then continue the sum
    idle(6);
    send(25'd1, 25'd1, 18'd50, 48'd0, 5'b00010, "R10 feedback after gap");
    send(25'd9, 25'd2, 18'd3, 48'd0, 5'b00110, "R8 feedback subtract");
    // R3 truncation of pre-adder
    send(25'd1, 25'h0FFFFFF, 18'd2, 48'd0, 5'b00000, "R3 pre-add truncation");
    // R6 extreme product
    send(25'h1000000, 25'd0, 18'h20000, 48'd0, 5'b10000, "R6 extreme product");
    send(25'h1000000, 25'd0, 18'h1FFFF, 48'd0, 5'b10000, "R6 negative extreme");
    // R9 wrap
    send(25'd1, 25'd0, 18'd1, 48'h7FFF_FFFF_FFFF, 5'b10001, "R9 wrap positive");
    send(25'd1, 25'd0, 18'd1, 48'h0, 5'b10101, "R9 wrap below zero");
    send(25'h0FFFFFF, 25'd0, 18'h1FFFF, 48'd0, 5'b10010, "R9 feedback wrap");
    for (int i = 0; i < 40; i++)
      send(25'h0FFFFFF, 25'd0, 18'h1FFFF, 48'd0, 5'b10010, "R9 long accumulate");
    // R2 mixed stream
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      send(25'($urandom), 25'($urandom), 18'($urandom), {16'($urandom), 32'($urandom)},
           5'($urandom), "R2 mixed stream");
    end
    // R1 mid-run reset
    do_reset();
    send(25'd7, 25'd0, 18'd7, 48'd0, 5'b10010, "R1 feedback after reset");
    idle(8);
    chk(exp_q.size() == 0, "R2 all results seen", 48'(exp_q.size()), 48'd0);
    finish_run();
  end
endmodule